// File: doc/BRIEF.md
# Round-Robin Request Arbiter with Carry-Chain Selection

This block shares one resource among a parameterizable number of requesters. It looks at the request vector and grants exactly one active requester in the same cycle. A registered one-hot copy of the most recent winner steers the choice, so that service rotates upward through the requester indices.

Both selection steps use two's-complement arithmetic so that they map onto fast carry chains. The lowest set bit of a vector is isolated with `x & -x`. The rotation mask comes from turning the previous one-hot winner into a thermometer code with `(p-1)|p` and inverting it, which leaves only the requesters above the previous winner. If none of those is active, the arbiter falls back to plain fixed priority, with index 0 strongest, and so wraps around. A binary index of the winner and a valid flag are provided next to the one-hot grant.

Top module: `rrc_arbiter`

## Requirements
- R1: Reset (synchronous, active high `rst`) clears the last-winner state. The first grant after reset goes to the lowest-indexed active requester, and index 0 has the highest priority.
- R2: At most one bit of `gnt` is set, and a set bit always belongs to an active request.
- R3: When `req` is all zeros, `gnt` is all zeros and `gnt_valid` is low.
- R4: `gnt_valid` is high exactly when a grant bit is set. `gnt_idx` then holds the binary position of that bit, counted with bit 0 of `gnt` as position 0.
- R5: The last-winner state is loaded at a rising clock edge only while a grant is given. A cycle without requests leaves it unchanged.
- R6: If any requester with a higher index than the last winner is active, the grant goes to the lowest-indexed of those.
- R7: If no requester above the last winner is active, the grant wraps to the lowest-indexed active requester, which may be the last winner itself.
- R8: With a constant request vector, every active requester is granted exactly once before any of them is granted a second time.
- R9: The grant follows `req` combinationally within the same cycle. No clock edge is needed between a request change and the matching grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; last-winner state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_REQ | Request vector, one bit per requester |
| gnt | output | N_REQ | One-hot grant vector (all zeros when idle) |
| gnt_valid | output | 1 | High when a grant is given |
| gnt_idx | output | IDX_W | Binary index of the granted requester |

## Verification
The bound checker keeps its own record of the last granted index. On every cycle it checks that the grant is one-hot and lies within the requests, that valid and index agree with the grant, and that the chosen index is the lowest one above the last winner or, failing that, the lowest one overall. It also checks fixed priority right after reset. Only the bench scenarios can show fairness over a whole rotation with steady requests, that an idle cycle preserves the rotation point, and that a reset in the middle of a run brings back fixed priority, because these depend on sequences of cycles that the bench lays out on purpose.

// File: rtl/rrc_arb_pkg.sv
package rrc_arb_pkg;

   // Choice of lowest-set-bit isolation structure
   typedef enum logic [0:0] {
      ISO_CARRY  = 1'b0,   // two's-complement x & -x, carry-chain friendly
      ISO_RIPPLE = 1'b1    // explicit "already seen" chain
   } iso_impl_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rrc_lsb_isolate.sv
module rrc_lsb_isolate
   import rrc_arb_pkg::*;
#(
   parameter int        WIDTH = 8,
   parameter iso_impl_e IMPL  = ISO_CARRY
) (
   input  logic [WIDTH-1:0] vec_in,
   output logic [WIDTH-1:0] lsb_out
);

   generate
      if (IMPL == ISO_CARRY) begin : g_carry
         // Negation via invert-plus-one keeps only the lowest set bit after AND
         assign lsb_out = vec_in & (~vec_in + WIDTH'(1));
      end else begin : g_ripple
         always_comb begin
            logic seen;
            seen    = 1'b0;
            lsb_out = '0;
            for (int i = 0; i < WIDTH; i++) begin
               lsb_out[i] = vec_in[i] & ~seen;
               seen       = seen | vec_in[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rrc_thermo_mask.sv
module rrc_thermo_mask #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] last_onehot,
   output logic [WIDTH-1:0] above_mask
);

   logic [WIDTH-1:0] thermo;

   // One-hot to thermometer: winner bit and everything beneath it set.
   // With no winner recorded the thermometer is all ones, so no bit survives.
   assign thermo     = (last_onehot - WIDTH'(1)) | last_onehot;
   assign above_mask = ~thermo;

endmodule

// File: rtl/rrc_onehot_index.sv
module rrc_onehot_index #(
   parameter int WIDTH = 8,
   parameter int IW    = 3
) (
   input  logic [WIDTH-1:0] onehot,
   output logic [IW-1:0]    index
);

   always_comb begin
      index = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (onehot[i]) index = index | IW'(i);
      end
   end

endmodule

// File: rtl/rrc_arbiter.sv
module rrc_arbiter
   import rrc_arb_pkg::*;
#(
   parameter int        N_REQ    = 27,
   parameter iso_impl_e ISO_IMPL = ISO_CARRY,
   localparam int       IDX_W    = idx_width(N_REQ)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] gnt,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);

   generate
      if (N_REQ < 2) begin : g_bad_width
         $error("rrc_arbiter: N_REQ must be at least 2");
      end
      if ((1 << IDX_W) < N_REQ) begin : g_bad_idx
         $error("rrc_arbiter: index width too narrow");
      end
   endgenerate

   logic [N_REQ-1:0] last_q;
   logic [N_REQ-1:0] above;
   logic [N_REQ-1:0] req_above;
   logic [N_REQ-1:0] pick_above;
   logic [N_REQ-1:0] pick_fixed;

   rrc_thermo_mask #(.WIDTH(N_REQ)) u_mask (
      .last_onehot (last_q),
      .above_mask  (above)
   );

   assign req_above = req & above;

   rrc_lsb_isolate #(.WIDTH(N_REQ), .IMPL(ISO_IMPL)) u_iso_above (
      .vec_in  (req_above),
      .lsb_out (pick_above)
   );

   rrc_lsb_isolate #(.WIDTH(N_REQ), .IMPL(ISO_IMPL)) u_iso_fixed (
      .vec_in  (req),
      .lsb_out (pick_fixed)
   );

   // Wrap to fixed priority when nothing above the last winner asks
   assign gnt       = (|pick_above) ? pick_above : pick_fixed;
   assign gnt_valid = |gnt;

   rrc_onehot_index #(.WIDTH(N_REQ), .IW(IDX_W)) u_idx (
      .onehot (gnt),
      .index  (gnt_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         last_q <= '0;
      end else if (gnt_valid) begin
         last_q <= gnt;
      end
   end

endmodule

// File: rtl/rrc_arbiter_chk.sv
module rrc_arbiter_chk #(
   parameter int N_REQ = 27,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic [N_REQ-1:0] req,
   input logic [N_REQ-1:0] gnt,
   input logic             gnt_valid,
   input logic [IDX_W-1:0] gnt_idx
);

   logic             have_last;
   logic [IDX_W-1:0] last_idx;
   logic [N_REQ-1:0] above_last;
   logic [N_REQ-1:0] below_gnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_last <= 1'b0;
         last_idx  <= '0;
      end else if (gnt_valid) begin
         have_last <= 1'b1;
         last_idx  <= gnt_idx;
      end
   end

   always_comb begin
      for (int i = 0; i < N_REQ; i++) begin
         above_last[i] = have_last && (i > int'(last_idx));
         below_gnt[i]  = (i < int'(gnt_idx));
      end
   end

   a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));

   a_r2_subset: assert property (@(posedge clk) disable iff (rst)
      (gnt & ~req) == '0);

   a_r3_idle: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |-> (gnt == '0 && !gnt_valid));

   a_r4_valid: assert property (@(posedge clk) disable iff (rst)
      gnt_valid == (gnt != '0));

   a_r4_index: assert property (@(posedge clk) disable iff (rst)
      gnt_valid |-> gnt[gnt_idx]);

   a_r1_fixed_after_reset: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && gnt_valid) |-> ((req & below_gnt) == '0));

   a_r6_rotate_up: assert property (@(posedge clk) disable iff (rst)
      ((req & above_last) != '0) |->
         (gnt_idx > last_idx && (req & above_last & below_gnt) == '0));

   a_r7_wrap_low: assert property (@(posedge clk) disable iff (rst)
      ((req & above_last) == '0 && req != '0) |->
         (gnt_valid && (req & below_gnt) == '0));

endmodule

bind rrc_arbiter rrc_arbiter_chk #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/rrc_arbiter_tb.sv
module rrc_arbiter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int IW         = 3;
   localparam int NVEC       = 14;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  gnt;
   logic          gnt_valid;
   logic [IW-1:0] gnt_idx;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   rrc_arbiter #(.N_REQ(N)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .gnt       (gnt),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // {req, expected gnt}; one entry per cycle, reset state at start
   localparam logic [15:0] VEC [NVEC] = '{
      {8'h00, 8'h00},   // R3 idle
      {8'hA4, 8'h04},   // R1 first grant fixed priority -> bit2
      {8'hA4, 8'h20},   // R6 above 2 -> bit5
      {8'hA4, 8'h80},   // R6 above 5 -> bit7
      {8'hA4, 8'h04},   // R7 wrap -> bit2
      {8'h00, 8'h00},   // R5 idle, last winner kept at 2
      {8'h0B, 8'h08},   // R5 rotation resumes above 2 -> bit3
      {8'h0B, 8'h01},   // R7 wrap -> bit0
      {8'h01, 8'h01},   // R7 only requester is last winner
      {8'hFF, 8'h02},   // R6 -> bit1
      {8'h05, 8'h04},   // R6 -> bit2
      {8'h80, 8'h80},   // R6 -> bit7
      {8'h80, 8'h80},   // R7 single requester repeated
      {8'h41, 8'h01}    // R7 wrap from top -> bit0
   };

   function automatic logic [IW-1:0] exp_index(input logic [N-1:0] g);
      logic [IW-1:0] r;
      r = '0;
      for (int i = 0; i < N; i++) if (g[i]) r = IW'(i);
      return r;
   endfunction

   task automatic check_out(input string tag, input logic [N-1:0] exp_g);
      logic          exp_v;
      logic [IW-1:0] exp_i;
      exp_v = (exp_g != '0);
      exp_i = exp_index(exp_g);
      n_tests++;
      if (gnt !== exp_g || gnt_valid !== exp_v || (exp_v && gnt_idx !== exp_i)) begin
         n_fail++;
         $display("FAIL %s: req=%h gnt=%h valid=%b idx=%0d expected gnt=%h valid=%b idx=%0d",
                  tag, req, gnt, gnt_valid, gnt_idx, exp_g, exp_v, exp_i);
      end
   endtask

   // Drive after a rising edge, check at the following falling edge
   task automatic apply(input logic [N-1:0] r);
      @(posedge clk);
      #1 req = r;
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [N-1:0] seen;
      // Reset state (R1, R3)
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_out("R1 reset idle outputs", 8'h00);
      #1 req = 8'hA4;
      #1 check_out("R9 combinational grant in reset", 8'h04);
      @(posedge clk);
      #1 req = '0; rst = 1'b0;
      @(negedge clk);

      // Table walk (R1..R7)
      for (int k = 0; k < NVEC; k++) begin
         apply(VEC[k][15:8]);
         check_out($sformatf("R6/R7 vector %0d", k), VEC[k][7:0]);
      end

      // R9: change request mid-cycle, grant follows without an edge
      // last winner is bit0; 0x30 -> bit4, then 0x12 -> bit1
      @(posedge clk);
      #1 req = 8'h30;
      #1 check_out("R9 first value", 8'h10);
      #1 req = 8'h12;
      #1 check_out("R9 second value", 8'h02);
      @(negedge clk);

      // R1: reset mid-run restores fixed priority
      @(posedge clk);
      #1 rst = 1'b1; req = '0;
      @(posedge clk);
      #1 rst = 1'b0;
      apply(8'hC6);
      check_out("R1 fixed priority after mid-run reset", 8'h02);

      // R8: constant full request, each granted exactly once per round
      seen = '0;
      for (int c = 0; c < N; c++) begin
         apply(8'hFF);
         n_tests++;
         if ((seen & gnt) != '0 || !$onehot(gnt)) begin
            n_fail++;
            $display("FAIL R8 fairness cycle %0d: gnt=%h seen=%h expected new single bit",
                     c, gnt, seen);
         end
         seen = seen | gnt;
      end
      n_tests++;
      if (seen !== 8'hFF) begin
         n_fail++;
         $display("FAIL R8 round coverage: seen=%h expected ff", seen);
      end

      // R3/R5: idle then single requester below last winner wraps
      apply(8'h00);
      check_out("R3 idle after round", 8'h00);
      apply(8'h01);
      check_out("R7 lone low requester", 8'h01);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule